// File: doc/BRIEF.md
# Protected Page-Load Write Engine

This block is the device-side write controller of a byte-wide nonvolatile memory that is modelled in on-chip RAM. A host drives a synchronous strobe interface: an address, a data byte, a one-cycle write strobe and a one-cycle read strobe. Writes are locked at all times. Each write session has to open with a fixed three-step unlock pattern. After that, the host may deposit between one and a full page of bytes into a page buffer, and each deposited byte sets its own valid flag.

The load has no explicit end command. When the host stops strobing for longer than a programmable gap, the engine closes the load and enters a write cycle of fixed length. During that cycle it copies only the flagged bytes into the storage array. At the end of the cycle the engine locks itself again. A write strobe that arrives while the engine is locked, and that does not start the pattern, still runs a write cycle of the same length but stores nothing. All times are counted in clock cycles. WC_CYCLES must be at least the page size.

Top module: `page_load_write_engine`

## Requirements
- R1: Unlocking takes three write strobes in a row, comparing only address bits 14:0. The first carries byte 0xAA to 0x5555, the second 0x55 to 0x2AAA and the third 0xA0 to 0x5555. Strobes that follow are loaded and later stored at their addresses.
- R2: The three unlock bytes never reach the array. The unlock addresses can still be loaded and stored like any other location.
- R3: Address bits 6:0 select the byte within a page. Bytes of one load may arrive in any order. A repeated offset keeps the last byte written to it. Only loaded offsets are written, and every other byte of the page keeps its old content.
- R4: Address bits above bit 6 select the page, and the first loaded byte fixes the page for the whole load. A strobe for a different page is dropped without disturbing the load, and proto_err goes high for the one cycle after it.
- R5: A strobe that comes at most LOAD_TO cycles after the previous accepted strobe of a load joins that load. If no strobe arrives in that window, busy rises LOAD_TO+1 cycles after the last accepted strobe.
- R6: A write strobe in the locked state that does not match the first unlock step raises busy in the next cycle and stores nothing.
- R7: When a write cycle ends, the engine is locked again, so a plain write that follows stores nothing.
- R8: A mismatch on the second or third unlock step sends the engine back to the locked state without raising busy.
- R9: Write strobes that arrive while busy is high are ignored and raise no error.
- R10: busy stays high for exactly WC_CYCLES cycles per write cycle.
- R11: After reset, busy, proto_err and bus_rdata are 0. A read strobe returns the stored byte at address bits MEM_AW-1:0 on bus_rdata in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| busy | output | 1 | Write cycle in progress |
| proto_err | output | 1 | Pulse: write for a foreign page was dropped |

## Verification
The hardest case to reach is the exact edge of the byte-load window. A strobe placed exactly LOAD_TO cycles after the previous one must still join the load, and one placed a single cycle later must land in the busy write cycle and be lost. The stimulus counts falling clock edges after each accepted strobe so it can place the next strobe on the last accepted cycle and on the first rejected cycle. It then confirms both outcomes by reading the affected bytes back after the commit. A second case that is hard to reach is an unlock sequence that breaks at its third step. The stimulus sends the first two steps correctly and then a wrong third step, and checks that busy stays low.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEQ1,
        ST_SEQ2,
        ST_LOAD,
        ST_PROG
    } pwe_state_e;
endpackage

// File: rtl/pwe_unlock_match.sv
module pwe_unlock_match #(
    parameter int CMP_W  = 15,
    parameter int DATA_W = 8
) (
    input  logic [1:0]        step,
    input  logic [CMP_W-1:0]  addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit
);
    localparam int NSTEP = 3;

    logic [NSTEP-1:0] step_hit;

    for (genvar k = 0; k < NSTEP; k++) begin : g_step
        localparam logic [CMP_W-1:0]  K_ADDR = (k == 1) ? CMP_W'(15'h2AAA) : CMP_W'(15'h5555);
        localparam logic [DATA_W-1:0] K_DATA = (k == 0) ? DATA_W'(8'hAA)
                                             : (k == 1) ? DATA_W'(8'h55) : DATA_W'(8'hA0);
        assign step_hit[k] = (addr == K_ADDR) && (data == K_DATA);
    end

    always_comb begin
        hit = 1'b0;
        if (step < 2'(NSTEP)) hit = step_hit[step];
    end
endmodule

// File: rtl/pwe_page_buf.sv
module pwe_page_buf #(
    parameter int OFS_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag
);
    localparam int NBYTE = 1 << OFS_W;

    logic [DATA_W-1:0] slot_q [NBYTE];
    logic [NBYTE-1:0]  flag_q;

    always_ff @(posedge clk) begin
        if (wr_en) slot_q[wr_ofs] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) flag_q <= '0;
        else if (wr_en)    flag_q[wr_ofs] <= 1'b1;
    end

    assign rd_data = slot_q[rd_ofs];
    assign rd_flag = flag_q[rd_ofs];
endmodule

// File: rtl/pwe_store.sv
module pwe_store #(
    parameter int AW     = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= cell_q[raddr];
    end
endmodule

// File: rtl/page_load_write_engine.sv
module page_load_write_engine
    import pwe_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int OFS_W      = 7,
    parameter int MEM_AW     = 10,
    parameter int LOAD_TO    = 15000,
    parameter int WC_CYCLES  = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              proto_err
);
    localparam int PG_W       = ADDR_W - OFS_W;
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int CNT_MAX    = (LOAD_TO > WC_CYCLES) ? LOAD_TO : WC_CYCLES;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam int CMP_W      = 15;
    localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(LOAD_TO - 1);
    localparam logic [CNT_W-1:0] WC_LAST = CNT_W'(WC_CYCLES - 1);
    localparam logic [CNT_W-1:0] PG_END  = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        pwe_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [PG_W-1:0]  page;
        logic             have_page;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              seq_hit;
    logic [1:0]        seq_step;
    logic [PG_W-1:0]   in_page;
    logic              buf_we, buf_clr;
    logic [OFS_W-1:0]  commit_ofs;
    logic [DATA_W-1:0] commit_data;
    logic              commit_flag;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr;

    assign in_page    = bus_addr[ADDR_W-1:OFS_W];
    assign commit_ofs = ctl_q.cnt[OFS_W-1:0];

    always_comb begin
        case (ctl_q.st)
            ST_SEQ1: seq_step = 2'd1;
            ST_SEQ2: seq_step = 2'd2;
            default: seq_step = 2'd0;
        endcase
    end

    pwe_unlock_match #(.CMP_W(CMP_W), .DATA_W(DATA_W)) u_match (
        .step (seq_step),
        .addr (bus_addr[CMP_W-1:0]),
        .data (bus_wdata),
        .hit  (seq_hit)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = 1'b0;
        buf_we    = 1'b0;
        buf_clr   = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (bus_wr) begin
                    ctl_d.cnt = '0;
                    ctl_d.st  = seq_hit ? ST_SEQ1 : ST_PROG;
                end
            end
            ST_SEQ1: begin
                if (bus_wr) ctl_d.st = seq_hit ? ST_SEQ2 : ST_IDLE;
            end
            ST_SEQ2: begin
                if (bus_wr) begin
                    ctl_d.st        = seq_hit ? ST_LOAD : ST_IDLE;
                    ctl_d.cnt       = '0;
                    ctl_d.have_page = 1'b0;
                end
            end
            ST_LOAD: begin
                if (bus_wr && (!ctl_q.have_page || in_page == ctl_q.page)) begin
                    buf_we          = 1'b1;
                    ctl_d.page      = in_page;
                    ctl_d.have_page = 1'b1;
                    ctl_d.cnt       = '0;
                end else begin
                    if (bus_wr) ctl_d.err = 1'b1;
                    if (ctl_q.cnt == TO_LAST) begin
                        ctl_d.st  = ST_PROG;
                        ctl_d.cnt = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (ctl_q.cnt == WC_LAST) begin
                    ctl_d.st        = ST_IDLE;
                    ctl_d.cnt       = '0;
                    ctl_d.have_page = 1'b0;
                    buf_clr         = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st        <= ST_IDLE;
            ctl_q.cnt       <= '0;
            ctl_q.page      <= '0;
            ctl_q.have_page <= 1'b0;
            ctl_q.err       <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pwe_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_ofs  (bus_addr[OFS_W-1:0]),
        .wr_data (bus_wdata),
        .clr     (buf_clr),
        .rd_ofs  (commit_ofs),
        .rd_data (commit_data),
        .rd_flag (commit_flag)
    );

    assign mem_we    = (ctl_q.st == ST_PROG) && (ctl_q.cnt < PG_END) && commit_flag;
    assign mem_waddr = MEM_AW'({ctl_q.page, commit_ofs});

    pwe_store #(.AW(MEM_AW), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (commit_data),
        .re    (bus_rd),
        .raddr (bus_addr[MEM_AW-1:0]),
        .rdata (bus_rdata)
    );

    pwe_state_e      st_now;
    logic [PG_W-1:0] page_now;
    logic            have_page_now;

    assign st_now        = ctl_q.st;
    assign page_now      = ctl_q.page;
    assign have_page_now = ctl_q.have_page;
    assign busy          = (ctl_q.st == ST_PROG);
    assign proto_err     = ctl_q.err;
endmodule

// File: rtl/pwe_checker.sv
module pwe_checker
    import pwe_pkg::*;
#(
    parameter int PG_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            busy,
    input logic            proto_err,
    input logic            mem_we,
    input pwe_state_e      st_now,
    input logic [PG_W-1:0] page_now,
    input logic            have_page_now
);
    AST_ERR_FROM_LOAD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> ($past(bus_wr) && $past(st_now) == ST_LOAD)); // R4

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_now == ST_LOAD && $past(st_now) == ST_LOAD && $past(have_page_now)) |-> $stable(page_now)); // R4

    AST_STORE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R3

    AST_BUSY_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr) |=> !proto_err); // R9

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(bus_wr) || $past(st_now) == ST_LOAD)); // R6

    AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (st_now == ST_IDLE)); // R7
endmodule

bind page_load_write_engine pwe_checker #(.PG_W(PG_W)) u_pwe_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .busy          (busy),
    .proto_err     (proto_err),
    .mem_we        (mem_we),
    .st_now        (st_now),
    .page_now      (page_now),
    .have_page_now (have_page_now)
);

// File: tb/page_load_write_engine_bench.sv
module page_load_write_engine_bench;
    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int LDTO   = 20;
    localparam int WC     = 200;
    localparam int NVEC   = 6;
    // {offset, data} pairs for a partial load of page 3
    localparam logic [15:0] VEC [NVEC] = '{16'h05_11, 16'h7F_22, 16'h00_33,
                                          16'h05_44, 16'h40_55, 16'h10_66};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              busy, proto_err;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] model [1024];

    always #2 clk = ~clk;

    page_load_write_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(7), .MEM_AW(10),
        .LOAD_TO(LDTO), .WC_CYCLES(WC)
    ) u_page_load_write_engine (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .busy(busy), .proto_err(proto_err)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic unlock();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h05555, 8'hA0);
    endtask

    task automatic wait_prog(string req);
        int n;
        n = 0;
        while (!busy && n < LDTO + 8) begin @(negedge clk); n++; end
        n = 0;
        while (busy && n < WC + 8) begin @(negedge clk); n++; end
        chk(req, {7'd0, busy}, 8'h00);
    endtask

    task automatic rd_chk(string req, logic [ADDR_W-1:0] a, logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        idle(3);
        // R11 reset state
        chk("R11 reset busy", {7'd0, busy}, 8'h00);
        chk("R11 reset err", {7'd0, proto_err}, 8'h00);
        chk("R11 reset rdata", bus_rdata, 8'h00);
        rst_n = 1'b1;
        idle(2);

        // R1: full page 3 load after unlock
        unlock();
        for (int i = 0; i < 128; i++) begin
            wr(17'h00180 + 17'(i), 8'(i) ^ 8'h5A);
            model[10'h180 + 10'(i)] = 8'(i) ^ 8'h5A;
        end
        wait_prog("R1 done");
        for (int i = 0; i < 128; i += 9) rd_chk("R1 stored", 17'h00180 + 17'(i), model[10'h180 + 10'(i)]);
        // R11 read latency: data valid the cycle after the strobe
        rd_chk("R11 latency", 17'h00185, model[10'h185]);

        // R2: unlock addresses are ordinary locations
        unlock(); wr(17'h05555, 8'h3C); wait_prog("R2 a");
        unlock(); wr(17'h02AAA, 8'hC3); wait_prog("R2 b");
        model[10'h155] = 8'h3C; model[10'h2AA] = 8'hC3;

        // R3: partial load from the vector table, repeated offset, any order
        unlock();
        for (int i = 0; i < NVEC; i++) begin
            wr(17'h00180 + 17'(VEC[i][15:8]), VEC[i][7:0]);
            model[10'h180 + 10'(VEC[i][15:8])] = VEC[i][7:0];
        end
        wait_prog("R3 done");
        for (int i = 0; i < 128; i++) rd_chk("R3 page", 17'h00180 + 17'(i), model[10'h180 + 10'(i)]);
        rd_chk("R2 unlock byte 0x5555 not stored", 17'h05555, 8'h3C);
        rd_chk("R2 unlock byte 0x2AAA not stored", 17'h02AAA, 8'hC3);

        // R4: foreign page during load
        unlock();
        wr(17'h00181, 8'h77);
        wr(17'h00155, 8'h99);
        chk("R4 err pulse", {7'd0, proto_err}, 8'h01);
        @(negedge clk);
        chk("R4 err one cycle", {7'd0, proto_err}, 8'h00);
        wr(17'h00182, 8'h88);
        wait_prog("R4 done");
        model[10'h181] = 8'h77; model[10'h182] = 8'h88;
        rd_chk("R4 kept 181", 17'h00181, 8'h77);
        rd_chk("R4 kept 182", 17'h00182, 8'h88);
        rd_chk("R4 foreign dropped", 17'h00155, 8'h3C);

        // R5: strobe exactly LOAD_TO cycles later joins the load
        unlock();
        wr(17'h00183, 8'hA1);
        idle(LDTO - 2);
        wr(17'h00184, 8'hA2);
        idle(LDTO - 1);
        chk("R5 busy low at window end", {7'd0, busy}, 8'h00);
        @(negedge clk);
        chk("R5 busy after timeout", {7'd0, busy}, 8'h01);
        // R10 busy length
        n = 1;
        while (n < WC + 5) begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
        chk("R10 busy cycles", 8'(n), 8'(WC));
        model[10'h183] = 8'hA1; model[10'h184] = 8'hA2;
        rd_chk("R5 first byte", 17'h00183, 8'hA1);
        rd_chk("R5 edge byte", 17'h00184, 8'hA2);

        // R5/R9: one cycle too late lands in the busy write cycle
        unlock();
        wr(17'h00185, 8'hB1);
        idle(LDTO - 1);
        wr(17'h00186, 8'hB2);
        chk("R9 no err while busy", {7'd0, proto_err}, 8'h00);
        wait_prog("R9 done");
        model[10'h185] = 8'hB1;
        rd_chk("R5 in-window byte", 17'h00185, 8'hB1);
        rd_chk("R9 late byte ignored", 17'h00186, model[10'h186]);

        // R7 and R6: plain write after a finished cycle
        wr(17'h00187, 8'h00);
        chk("R6 busy from locked write", {7'd0, busy}, 8'h01);
        n = 1;
        while (n < WC + 5) begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
        chk("R10 dummy busy cycles", 8'(n), 8'(WC));
        rd_chk("R7 relocked no store", 17'h00187, model[10'h187]);

        // R8: broken third step
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
        wr(17'h02AAA, 8'hA0);
        chk("R8 no busy on mismatch", {7'd0, busy}, 8'h00);
        idle(2);
        chk("R8 still idle", {7'd0, busy}, 8'h00);
        wr(17'h00188, 8'h01);
        chk("R6 locked write starts cycle", {7'd0, busy}, 8'h01);
        wait_prog("R6 done");
        rd_chk("R6 nothing stored", 17'h00188, model[10'h188]);

        // R8: broken second step
        wr(17'h05555, 8'hAA);
        wr(17'h05555, 8'h55);
        chk("R8 step2 mismatch no busy", {7'd0, busy}, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule